// File: doc/BRIEF.md
# MMU fault status generator

This block sits on a processor's memory access path, in front of an address-translation lookup that lives elsewhere. Each access request carries an address and an access kind. The block first decides whether translation is in force. Translation needs three things: the MMU capability bit is set, the virtual-mode enable is set, and the extended capability check does not veto it. When translation is off, the address passes through identity-mapped, aligned down to its 4 KiB page. When translation is on and the lookup hits, the block relocates the page by the entry's base pair.

When translation is on and the lookup fails, the block does three things. It captures the faulting address. It encodes the failure kind and the access direction into a status word. It raises a fault request that stays high until the core acknowledges it. A second failure while a fault is still outstanding is fatal. It parks the block in a halted state, flagged on a separate output, until reset.

The control is a three-state machine:
- ST_IDLE: no fault outstanding.
- ST_PEND: a fault has been reported and not yet acknowledged.
- ST_HALT: a recursive fault has occurred.

Its transitions are:
- IDLE→PEND on a failed lookup.
- PEND→IDLE on acknowledge with no new failure.
- PEND→HALT on a failed lookup while pending, whether or not acknowledge is high in that cycle.
- HALT is left only by reset.

All outputs are registered: results appear one clock after the request.

Top module: `mmu_fault_unit`

## Requirements
- R1: While reset is asserted and in the first cycle after it, `pa_out`, `pa_valid`, `fault_addr`, `fault_status`, `fault_req` and `recur_err` are all zero.
- R2: When `cap_mmu` is 0 or `vm_en` is 0, a request (`req_valid`=1) yields `pa_valid`=1 one cycle later with `pa_out` equal to `req_addr` with bits [11:0] cleared. In this mode the lookup inputs have no effect: a lookup miss raises no fault.
- R3: When `cap_ext`=1 and `cap2_mmu`=0, translation is bypassed exactly as in R2, even with `cap_mmu`=1 and `vm_en`=1.
- R4: When translation is on and `lk_hit`=1, `pa_out` one cycle later equals `lk_pbase + ((req_addr with bits [11:0] cleared) - lk_vbase)`, modulo 2^32, with `pa_valid`=1.
- R5: A failed lookup with `lk_miss`=0 (protection fault) gives `fault_status` low bits 17 for a fetch (`req_kind`=2) and 16 for a load (`req_kind`=0) or store (`req_kind`=1).
- R6: A failed lookup with `lk_miss`=1 (miss fault) gives `fault_status` low bits 19 for a fetch and 18 for a load or store.
- R7: `fault_status` bit 10 is 1 exactly when the faulting access was a store (`req_kind`=1). All bits other than [4:0] and 10 are 0.
- R8: On a failed lookup from the idle state, `fault_addr` captures the full `req_addr` and `fault_req` rises one cycle later. The faulting request produces no `pa_valid`.
- R9: `fault_req` stays high until a cycle with `fault_ack`=1 and no new failure, and falls one cycle after that cycle.
- R10: A failed lookup while `fault_req` is high sets `recur_err` one cycle later. `recur_err` and `fault_req` then stay high until reset, and `fault_addr` and `fault_status` keep their first-fault values.
- R11: `pa_valid` is 1 only in the cycle after an accepted, non-faulting request. After `recur_err` is set, requests produce no `pa_valid` and no change of `pa_out`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Access request present this cycle |
| req_addr | input | 32 | Access (virtual) address |
| req_kind | input | 2 | 0 load, 1 store, 2 fetch |
| cap_mmu | input | 1 | Base capability: MMU present |
| cap_ext | input | 1 | Extended capability set is present |
| cap2_mmu | input | 1 | Extended capability reports MMU |
| vm_en | input | 1 | Virtual-mode enable from machine status |
| lk_hit | input | 1 | Lookup hit |
| lk_miss | input | 1 | On a failed lookup: 1 miss, 0 protection |
| lk_pbase | input | 32 | Physical base of the hit entry |
| lk_vbase | input | 32 | Virtual base of the hit entry |
| fault_ack | input | 1 | Core acknowledges the pending fault |
| pa_out | output | 32 | Physical page address |
| pa_valid | output | 1 | One-cycle pulse: `pa_out` updated |
| fault_addr | output | 32 | Captured faulting address |
| fault_status | output | 32 | Exception status code |
| fault_req | output | 1 | MMU exception request |
| recur_err | output | 1 | Fatal recursive fault |

## Verification
Some properties are checked by assertions on every cycle:
- a fault request holds until acknowledge, and the recursive error is sticky and implies an active request;
- the captured address and status freeze while a fault is outstanding;
- every new fault carries a code in the 16–19 range and is not accompanied by a translation pulse;
- any bypassed request produces a page-aligned copy of its address one cycle later.

Other properties only the bench's scenarios can show, since they depend on the exact values of the lookup's base pair and the access kind:
- the relocation arithmetic, including wraparound below the virtual base;
- the exact fetch/data and store distinction of each code;
- the veto from the extended capability set;
- the choice of recursion over acknowledge when both arrive in one cycle.

// File: rtl/mfu_pkg.sv
package mfu_pkg;
    typedef enum logic [1:0] {
        ACC_LOAD  = 2'd0,
        ACC_STORE = 2'd1,
        ACC_FETCH = 2'd2
    } acc_kind_e;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_PEND = 2'd1,
        ST_HALT = 2'd2
    } fsm_state_e;

    localparam int CODE_PROT_DATA = 16;
    localparam int CODE_MISS_DATA = 18;
    localparam int STORE_BIT      = 10;
endpackage

// File: rtl/mfu_avail.sv
module mfu_avail #(
    parameter bit HONOR_EXT_CAP = 1'b1
) (
    input  logic cap_mmu,
    input  logic cap_ext,
    input  logic cap2_mmu,
    input  logic vm_en,
    output logic xlate_on
);
    logic mmu_present;

    generate
        if (HONOR_EXT_CAP) begin : g_ext
            assign mmu_present = cap_mmu && !(cap_ext && !cap2_mmu);
        end else begin : g_base
            logic unused_ext;
            assign unused_ext  = cap_ext ^ cap2_mmu;
            assign mmu_present = cap_mmu;
        end
    endgenerate

    assign xlate_on = mmu_present && vm_en;
endmodule

// File: rtl/mfu_xlate.sv
module mfu_xlate #(
    parameter int AW        = 32,
    parameter int PAGE_BITS = 12
) (
    input  logic [AW-1:0] addr,
    input  logic [AW-1:0] pbase,
    input  logic [AW-1:0] vbase,
    input  logic          xlate_on,
    output logic [AW-1:0] pa
);
    logic [AW-1:0] aligned;

    assign aligned = {addr[AW-1:PAGE_BITS], {PAGE_BITS{1'b0}}};
    assign pa      = xlate_on ? (pbase + (aligned - vbase)) : aligned;
endmodule

// File: rtl/mfu_code.sv
module mfu_code
    import mfu_pkg::*;
#(
    parameter int STAT_W = 32
) (
    input  logic [1:0]        kind,
    input  logic              miss,
    output logic [STAT_W-1:0] status
);
    localparam int BASE_W = 5;

    logic [BASE_W-1:0] base;

    always_comb begin
        base = miss ? BASE_W'(CODE_MISS_DATA) : BASE_W'(CODE_PROT_DATA);
        if (kind == ACC_FETCH) begin
            base = base + BASE_W'(1);
        end
        status                 = '0;
        status[BASE_W-1:0]     = base;
        status[STORE_BIT]      = (kind == ACC_STORE);
    end
endmodule

// File: rtl/mmu_fault_unit.sv
module mmu_fault_unit
    import mfu_pkg::*;
#(
    parameter int AW            = 32,
    parameter int PAGE_BITS     = 12,
    parameter int STAT_W        = 32,
    parameter bit HONOR_EXT_CAP = 1'b1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    input  logic [AW-1:0]     req_addr,
    input  logic [1:0]        req_kind,
    input  logic              cap_mmu,
    input  logic              cap_ext,
    input  logic              cap2_mmu,
    input  logic              vm_en,
    input  logic              lk_hit,
    input  logic              lk_miss,
    input  logic [AW-1:0]     lk_pbase,
    input  logic [AW-1:0]     lk_vbase,
    input  logic              fault_ack,
    output logic [AW-1:0]     pa_out,
    output logic              pa_valid,
    output logic [AW-1:0]     fault_addr,
    output logic [STAT_W-1:0] fault_status,
    output logic              fault_req,
    output logic              recur_err
);
    fsm_state_e        state, state_nx;
    logic              xlate_on;
    logic [AW-1:0]     pa_calc;
    logic [STAT_W-1:0] code_calc;
    logic              accept;
    logic              is_fault;
    logic              is_ok;

    mfu_avail #(.HONOR_EXT_CAP(HONOR_EXT_CAP)) u_avail (
        .cap_mmu  (cap_mmu),
        .cap_ext  (cap_ext),
        .cap2_mmu (cap2_mmu),
        .vm_en    (vm_en),
        .xlate_on (xlate_on)
    );

    mfu_xlate #(.AW(AW), .PAGE_BITS(PAGE_BITS)) u_xlate (
        .addr     (req_addr),
        .pbase    (lk_pbase),
        .vbase    (lk_vbase),
        .xlate_on (xlate_on),
        .pa       (pa_calc)
    );

    mfu_code #(.STAT_W(STAT_W)) u_code (
        .kind   (req_kind),
        .miss   (lk_miss),
        .status (code_calc)
    );

    always_comb begin
        accept   = req_valid && (state != ST_HALT);
        is_fault = accept && xlate_on && !lk_hit;
        is_ok    = accept && !is_fault;
    end

    always_comb begin
        state_nx = state;
        unique case (state)
            ST_IDLE: if (is_fault) state_nx = ST_PEND;
            ST_PEND: begin
                if (is_fault)       state_nx = ST_HALT;
                else if (fault_ack) state_nx = ST_IDLE;
            end
            ST_HALT: state_nx = ST_HALT;
            default: state_nx = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= state_nx;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pa_out       <= '0;
            pa_valid     <= 1'b0;
            fault_addr   <= '0;
            fault_status <= '0;
        end else begin
            pa_valid <= is_ok;
            if (is_ok) begin
                pa_out <= pa_calc;
            end
            if (is_fault && (state == ST_IDLE)) begin
                fault_addr   <= req_addr;
                fault_status <= code_calc;
            end
        end
    end

    assign fault_req = (state != ST_IDLE);
    assign recur_err = (state == ST_HALT);
endmodule

// File: rtl/mfu_checker.sv
module mfu_checker #(
    parameter int AW        = 32,
    parameter int PAGE_BITS = 12,
    parameter int STAT_W    = 32
) (
    input logic              clk,
    input logic              rst_n,
    input logic              req_valid,
    input logic [AW-1:0]     req_addr,
    input logic              vm_en,
    input logic              fault_ack,
    input logic [AW-1:0]     pa_out,
    input logic              pa_valid,
    input logic [AW-1:0]     fault_addr,
    input logic [STAT_W-1:0] fault_status,
    input logic              fault_req,
    input logic              recur_err
);
    assert_fault_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
        fault_req && !fault_ack |=> fault_req);

    assert_recur_sticky_R10: assert property (@(posedge clk) disable iff (!rst_n)
        recur_err |=> recur_err);

    assert_recur_has_req_R10: assert property (@(posedge clk) disable iff (!rst_n)
        recur_err |-> fault_req);

    assert_capture_frozen_R10: assert property (@(posedge clk) disable iff (!rst_n)
        fault_req && $past(fault_req) |-> $stable(fault_addr) && $stable(fault_status));

    assert_code_range_R5: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(fault_req) |-> fault_status[4] && (fault_status[3:2] == 2'b00));

    assert_no_pa_on_fault_R8: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(fault_req) |-> !pa_valid);

    assert_bypass_align_R2: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid && !vm_en && !recur_err |=> pa_valid
            && (pa_out[AW-1:PAGE_BITS] == $past(req_addr[AW-1:PAGE_BITS]))
            && (pa_out[PAGE_BITS-1:0] == '0));
endmodule

bind mmu_fault_unit mfu_checker #(.AW(AW), .PAGE_BITS(PAGE_BITS), .STAT_W(STAT_W)) u_mfu_checker (
    .clk          (clk),
    .rst_n        (rst_n),
    .req_valid    (req_valid),
    .req_addr     (req_addr),
    .vm_en        (vm_en),
    .fault_ack    (fault_ack),
    .pa_out       (pa_out),
    .pa_valid     (pa_valid),
    .fault_addr   (fault_addr),
    .fault_status (fault_status),
    .fault_req    (fault_req),
    .recur_err    (recur_err)
);

// File: tb/tb_mmu_fault_unit.sv
`timescale 1ns/1ps
module tb_mmu_fault_unit;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0;
    logic [31:0] req_addr = '0;
    logic [1:0]  req_kind = '0;
    logic        cap_mmu = 1'b0, cap_ext = 1'b0, cap2_mmu = 1'b0, vm_en = 1'b0;
    logic        lk_hit = 1'b0, lk_miss = 1'b0;
    logic [31:0] lk_pbase = '0, lk_vbase = '0;
    logic        fault_ack = 1'b0;
    logic [31:0] pa_out, fault_addr, fault_status;
    logic        pa_valid, fault_req, recur_err;

    int checks = 0;
    int fails  = 0;
    string tag = "R1";

    always #2 clk = ~clk;

    mmu_fault_unit dut (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_addr(req_addr),
        .req_kind(req_kind), .cap_mmu(cap_mmu), .cap_ext(cap_ext), .cap2_mmu(cap2_mmu),
        .vm_en(vm_en), .lk_hit(lk_hit), .lk_miss(lk_miss), .lk_pbase(lk_pbase),
        .lk_vbase(lk_vbase), .fault_ack(fault_ack), .pa_out(pa_out), .pa_valid(pa_valid),
        .fault_addr(fault_addr), .fault_status(fault_status), .fault_req(fault_req),
        .recur_err(recur_err)
    );

    // Behavioural reference model
    logic [31:0] m_pa, m_faddr, m_stat;
    logic        m_valid, m_freq, m_recur;
    bit          m_on, m_fault;
    int          m_code;

    always @(posedge clk) begin
        if (!rst_n) begin
            m_pa <= 0; m_valid <= 0; m_faddr <= 0; m_stat <= 0; m_freq <= 0; m_recur <= 0;
        end else begin
            m_valid <= 0;
            m_fault = 0;
            if (req_valid && !m_recur) begin
                m_on = cap_mmu && vm_en && !(cap_ext && !cap2_mmu);
                if (!m_on) begin
                    m_pa <= req_addr & 32'hFFFF_F000; m_valid <= 1;
                end else if (lk_hit) begin
                    m_pa <= lk_pbase + ((req_addr & 32'hFFFF_F000) - lk_vbase); m_valid <= 1;
                end else begin
                    m_fault = 1;
                end
            end
            if (m_fault && m_freq) begin
                m_recur <= 1;
            end else if (m_fault) begin
                m_code = (lk_miss ? 18 : 16) + (req_kind == 2 ? 1 : 0) + (req_kind == 1 ? 1024 : 0);
                m_freq <= 1; m_faddr <= req_addr; m_stat <= 32'(m_code);
            end else if (m_freq && fault_ack && !m_recur) begin
                m_freq <= 0;
            end
        end
    end

    task automatic compare();
        checks++;
        if (pa_out !== m_pa || pa_valid !== m_valid || fault_addr !== m_faddr ||
            fault_status !== m_stat || fault_req !== m_freq || recur_err !== m_recur) begin
            fails++;
            $display("FAIL %s: actual pa=%h v=%b fa=%h st=%h req=%b rec=%b expected pa=%h v=%b fa=%h st=%h req=%b rec=%b",
                tag, pa_out, pa_valid, fault_addr, fault_status, fault_req, recur_err,
                m_pa, m_valid, m_faddr, m_stat, m_freq, m_recur);
        end
    endtask

    task automatic step();
        @(posedge clk);
        @(negedge clk);
        compare();
    endtask

    task automatic access(input logic [31:0] a, input logic [1:0] k, input logic h,
                          input logic ms, input logic [31:0] pb, input logic [31:0] vb);
        req_valid = 1; req_addr = a; req_kind = k; lk_hit = h; lk_miss = ms;
        lk_pbase = pb; lk_vbase = vb;
        step();
        req_valid = 0; lk_hit = 0;
    endtask

    task automatic caps(input logic c, input logic e, input logic c2, input logic v);
        cap_mmu = c; cap_ext = e; cap2_mmu = c2; vm_en = v;
    endtask

    task automatic ack_fault();
        fault_ack = 1; step(); fault_ack = 0; step();
    endtask

    initial begin
        #(200000 * 4);
        fails++; checks++;
        $display("FAIL watchdog: actual hung expected finish");
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

    initial begin
        @(negedge clk);
        tag = "R1"; step(); step();
        rst_n = 1; step();

        tag = "R11"; step(); step();

        tag = "R2"; caps(0, 0, 0, 1);
        access(32'h1234_5678, 0, 0, 1, 32'hDEAD_0000, 0);
        access(32'hFFFF_FFFF, 2, 0, 0, 0, 0);
        caps(1, 0, 0, 0);
        access(32'h0000_0FFF, 1, 0, 1, 0, 0);

        tag = "R3"; caps(1, 1, 0, 1);
        access(32'hABCD_E123, 0, 0, 1, 0, 0);
        caps(1, 1, 1, 1);
        tag = "R4";
        access(32'h0040_1ABC, 0, 1, 0, 32'h8000_0000, 32'h0040_0000);
        access(32'h0000_0010, 2, 1, 0, 32'h0000_1000, 32'h0000_3000);
        caps(1, 0, 0, 1);
        access(32'h7000_5FFF, 1, 1, 0, 32'h1000_0000, 32'h7000_4000);

        tag = "R5"; access(32'h0001_2345, 2, 0, 0, 0, 0); step(); ack_fault();
        access(32'h0002_0004, 0, 0, 0, 0, 0); ack_fault();
        tag = "R7"; access(32'h0003_0008, 1, 0, 0, 0, 0); ack_fault();
        tag = "R6"; access(32'h0004_000C, 2, 0, 1, 0, 0); ack_fault();
        access(32'h0005_0010, 0, 0, 1, 0, 0); ack_fault();
        tag = "R7"; access(32'h0006_0014, 1, 0, 1, 0, 0); ack_fault();

        tag = "R9"; access(32'h0007_0018, 0, 0, 1, 0, 0);
        for (int i = 0; i < 4; i++) step();
        tag = "R8"; access(32'h0008_0000, 0, 1, 0, 32'h0009_0000, 32'h0008_0000);
        tag = "R9"; fault_ack = 1;
        access(32'h0000_1000, 1, 1, 0, 32'h2000_0000, 0);
        fault_ack = 0; step();

        tag = "R10"; access(32'h000A_0A0A, 2, 0, 0, 0, 0);
        fault_ack = 1; access(32'h000B_0B0B, 1, 0, 1, 0, 0); fault_ack = 0;
        step();
        tag = "R11"; access(32'h000C_0000, 0, 1, 0, 32'h5000_0000, 32'h000C_0000);
        caps(0, 0, 0, 0); access(32'h000D_0000, 0, 0, 0, 0, 0);
        fault_ack = 1; step(); fault_ack = 0; step();

        tag = "R1"; rst_n = 0; step(); rst_n = 1; step();
        tag = "R2"; access(32'h0000_2ABC, 0, 0, 1, 0, 0); step();

        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end
endmodule